// File: doc/BRIEF.md
# Serial Command and Result Port for a Sampling Converter

This block is the digital side of a sampling converter's serial port. A host lowers chip-select and toggles a serial clock; on each rising clock edge the block takes one bit of an 8-bit command word, and between rising edges it drives one bit of the previous conversion result. The command word carries five leading configuration bits, which are passed through unchanged to the analog section. It also carries an output-order bit and a 2-bit length code. The length code sets how many clocks the current transfer lasts, and one of its values requests power-down instead of a length.

All serial inputs are resynchronised into the system clock domain, so the serial clock must be well below the system clock. When a transfer completes, the block updates its configuration outputs and pulses a start-conversion strobe. The conversion engine hands the finished 12-bit result back on a parallel port with a one-cycle valid strobe. The output-order bit governs the word sent in the following transfer, which is the word carrying the result that this command's conversion produces.

Top module: `sercnv_ctrl`

## Requirements
- R1: During and after reset, and before any transfer: `sdo_oe`=0, `sdo`=0, `conv_start`=0, `pwr_down`=0, `cfg_lead`=0 and `cfg_msb_first`=1.
- R2: The command word is received first bit first. Received bits 1 to 5 go to `cfg_lead[4]` down to `cfg_lead[0]`. Bit 6 is the order bit (1 = MSB-first, 0 = LSB-first). Bits 7 and 8 form the length code {L1,L0}.
- R3: The length code sets the number of rising serial-clock edges in a transfer: 00 gives 8, 10 gives 12, 11 gives 16 and 01 gives 10. It applies to the transfer that carries it. With chip-select held low, the next rising edge starts a new transfer.
- R4: When the order in force is MSB-first, output bit k (k=0 first) is result[11-k] for k<12 and 0 for k≥12.
- R5: When the order in force is LSB-first, output bit k is result[k] for k<12 and 0 for k≥12. A shorter word is truncated to its first bits.
- R6: The order in force for a transfer's output is `cfg_msb_first`, latched from the last completed non-shutdown command. The order bit of the command being received does not change the current output.
- R7: At the end of a transfer whose length code is not 01, `cfg_lead` and `cfg_msb_first` take the command's values and `conv_start` pulses high for exactly one clock.
- R8: A transfer with length code 01 shifts out 10 bits, then sets `pwr_down`. It gives no `conv_start` and leaves `cfg_lead` and `cfg_msb_first` unchanged.
- R9: `pwr_down` clears on a falling chip-select, or on a rising serial clock while chip-select is low.
- R10: While chip-select is high, `sdo_oe`=0 and `sdo`=0. Raising chip-select before the last bit abandons the transfer: there is no `conv_start` and no configuration change, and the next transfer starts from bit 1.
- R11: `res_valid` captures `res_data`. The captured value is the result shifted out in the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command data, sampled on rising sclk |
| sdo | output | 1 | Serial result data, changed after falling sclk |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| res_data | input | RES_W | Conversion result |
| res_valid | input | 1 | One-cycle strobe qualifying res_data |
| conv_start | output | 1 | One-cycle pulse requesting a conversion |
| cfg_lead | output | 5 | Leading configuration bits of the last command |
| cfg_msb_first | output | 1 | Latched order bit of the last command |
| pwr_down | output | 1 | Power-down flag |

## Verification
The bit counter and the decoded length decide where a transfer ends. If either is wrong, `conv_start` appears on the wrong edge or not at all, and the configuration outputs miss their update. This shows within a clock or two of the host's final rising edge. A wrong output index or latched order corrupts `sdo` from the first bit of the next word onward. A wrong power-down state shows on `pwr_down` as soon as a shutdown transfer ends or a wake edge arrives. The directed transfers read every bit of every word and compare against words built from the latched order, so any of these faults appears in the affected transfer.

// File: rtl/sercnv_pkg.sv
`timescale 1ns/1ps
package sercnv_pkg;
  localparam int CMD_W  = 8;
  localparam int LEAD_W = 5;
  localparam int LEN_W  = 5;

  typedef enum logic [1:0] {
    LEN_8    = 2'b00,
    LEN_SHUT = 2'b01,
    LEN_12   = 2'b10,
    LEN_16   = 2'b11
  } len_code_t;

  function automatic logic [LEN_W-1:0] word_len(input len_code_t code);
    case (code)
      LEN_8:    return LEN_W'(8);
      LEN_SHUT: return LEN_W'(10);
      LEN_12:   return LEN_W'(12);
      default:  return LEN_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/sercnv_sync.sv
`timescale 1ns/1ps
module sercnv_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sercnv_frame.sv
`timescale 1ns/1ps
module sercnv_frame
  import sercnv_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_low,
  input  logic             cs_fall,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             sdi_s,
  output logic             done,
  output logic             done_shut,
  output logic [CMD_W-1:0] cmd_out,
  output logic [IDX_W-1:0] out_idx
);
  logic [LEN_W-1:0] cnt, cnt_nxt;
  logic [CMD_W-1:0] cmd, cmd_nxt;
  len_code_t        code_q, code_now;
  logic             restart, finish;

  always_comb begin
    cmd_nxt  = (cnt < LEN_W'(CMD_W)) ? {cmd[CMD_W-2:0], sdi_s} : cmd;
    code_now = (cnt == LEN_W'(CMD_W-1)) ? len_code_t'(cmd_nxt[1:0]) : code_q;
    cnt_nxt  = cnt + LEN_W'(1);
    finish   = sclk_rise && cs_low && (cnt_nxt >= LEN_W'(CMD_W)) &&
               (cnt_nxt == word_len(code_now));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cmd       <= '0;
      code_q    <= LEN_8;
      restart   <= 1'b0;
      out_idx   <= '0;
      done      <= 1'b0;
      done_shut <= 1'b0;
      cmd_out   <= '0;
    end else begin
      done      <= finish;
      done_shut <= finish && (code_now == LEN_SHUT);
      if (finish) cmd_out <= cmd_nxt;
      if (!cs_low || cs_fall) begin
        cnt     <= '0;
        cmd     <= '0;
        restart <= 1'b0;
        out_idx <= '0;
      end else begin
        if (sclk_rise) begin
          cmd <= cmd_nxt;
          if (cnt == LEN_W'(CMD_W-1)) code_q <= code_now;
          if (finish) begin
            cnt     <= '0;
            restart <= 1'b1;
          end else begin
            cnt <= cnt_nxt;
          end
        end
        if (sclk_fall) begin
          if (restart) begin
            out_idx <= '0;
            restart <= 1'b0;
          end else if (out_idx != '1) begin
            out_idx <= out_idx + IDX_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sercnv_outfmt.sv
`timescale 1ns/1ps
module sercnv_outfmt #(
  parameter int RES_W = 12,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_low,
  input  logic [RES_W-1:0] result,
  input  logic             msb_first,
  input  logic [IDX_W-1:0] idx,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0] msb_vec, lsb_vec;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < RES_W) begin : g_data
      assign msb_vec[k] = result[RES_W-1-k];
      assign lsb_vec[k] = result[k];
    end else begin : g_pad
      assign msb_vec[k] = 1'b0;
      assign lsb_vec[k] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sdo_oe <= cs_low;
      sdo    <= cs_low && (msb_first ? msb_vec[idx] : lsb_vec[idx]);
    end
  end
endmodule

// File: rtl/sercnv_ctrl.sv
`timescale 1ns/1ps
module sercnv_ctrl
  import sercnv_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [RES_W-1:0]  res_data,
  input  logic              res_valid,
  output logic              conv_start,
  output logic [LEAD_W-1:0] cfg_lead,
  output logic              cfg_msb_first,
  output logic              pwr_down
);
  localparam int IDX_W = LEN_W;

  logic [2:0]       pins_s;
  logic             cs_s, sclk_s, sdi_s, cs_d, sclk_d;
  logic             cs_low, cs_fall, sclk_rise, sclk_fall;
  logic             done, done_shut;
  logic [CMD_W-1:0] cmd_word;
  logic [IDX_W-1:0] out_idx;
  logic [RES_W-1:0] result_q;

  sercnv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(pins_s)
  );
  assign {cs_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_low    = ~cs_s;
  assign cs_fall   = cs_d & ~cs_s;
  assign sclk_rise = ~sclk_d & sclk_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  sercnv_frame #(.IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst(rst), .cs_low(cs_low), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .done(done), .done_shut(done_shut), .cmd_out(cmd_word), .out_idx(out_idx)
  );

  sercnv_outfmt #(.RES_W(RES_W), .IDX_W(IDX_W)) u_outfmt (
    .clk(clk), .rst(rst), .cs_low(cs_low), .result(result_q),
    .msb_first(cfg_msb_first), .idx(out_idx), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q      <= '0;
      conv_start    <= 1'b0;
      cfg_lead      <= '0;
      cfg_msb_first <= 1'b1;
      pwr_down      <= 1'b0;
    end else begin
      if (res_valid) result_q <= res_data;
      conv_start <= done && !done_shut;
      if (done && !done_shut) begin
        cfg_lead      <= cmd_word[CMD_W-1 -: LEAD_W];
        cfg_msb_first <= cmd_word[2];
      end
      if (done_shut)                             pwr_down <= 1'b1;
      else if (cs_fall || (sclk_rise && cs_low)) pwr_down <= 1'b0;
    end
  end
endmodule

// File: rtl/sercnv_ctrl_chk.sv
`timescale 1ns/1ps
module sercnv_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_start,
  input logic       pwr_down,
  input logic [4:0] cfg_lead,
  input logic       cfg_msb_first,
  input logic       sdo,
  input logic       sdo_oe
);
  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R7
  lead_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_lead) |-> conv_start);

  // R6
  order_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_msb_first) |-> conv_start);

  // R8
  shut_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_down) |-> !conv_start);

  // R10
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);

  // R1
  reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!conv_start && !pwr_down && !sdo_oe && cfg_msb_first));
endmodule

bind sercnv_ctrl sercnv_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .pwr_down(pwr_down),
  .cfg_lead(cfg_lead), .cfg_msb_first(cfg_msb_first), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/test_sercnv_ctrl.sv
`timescale 1ns/1ps
module test_sercnv_ctrl;
  logic        clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic        sdo, sdo_oe, conv_start, cfg_msb_first, pwr_down;
  logic [4:0]  cfg_lead;

  int checks = 0, fails = 0, conv_cnt = 0;
  logic        exp_msb = 1'b1;
  logic [11:0] exp_res = '0;
  logic [15:0] got;

  sercnv_ctrl i_sercnv_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .res_data(res_data), .res_valid(res_valid),
    .conv_start(conv_start), .cfg_lead(cfg_lead),
    .cfg_msb_first(cfg_msb_first), .pwr_down(pwr_down)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (!rst && conv_start) conv_cnt++;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_result(input logic [11:0] v);
    @(negedge clk); res_data = v; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
    exp_res = v;
  endtask

  function automatic logic exp_bit(input int k, input logic msb);
    if (k >= 12) return 1'b0;
    return msb ? exp_res[11-k] : exp_res[k];
  endfunction

  task automatic xfer(input logic [7:0] cmd, input int nbits, input bit keep_low,
                      output logic [15:0] bits);
    bits = '0;
    if (cs_n) begin cs_n = 1'b0; #60; end
    for (int i = 0; i < nbits; i++) begin
      #20 sdi = (i < 8) ? cmd[7-i] : 1'b0;
      #18 bits[i] = sdo;
      #2  sclk = 1'b1;
      #40 sclk = 1'b0;
    end
    #40;
    if (!keep_low) begin cs_n = 1'b1; #60; end
  endtask

  task automatic check_word(input string req, input logic [15:0] bits,
                            input int n, input logic msb);
    for (int i = 0; i < n; i++)
      check(req, bits[i], exp_bit(i, msb), $sformatf("sdo bit %0d", i));
  endtask

  task automatic t_reset;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", sdo_oe, 0, "sdo_oe");
    check("R1", sdo, 0, "sdo");
    check("R1", conv_start, 0, "conv_start");
    check("R1", pwr_down, 0, "pwr_down");
    check("R1", cfg_lead, 0, "cfg_lead");
    check("R1", cfg_msb_first, 1, "cfg_msb_first");
  endtask

  task automatic t_msb12;
    load_result(12'hA5C);
    xfer(8'hB6, 12, 1'b0, got);   // lead 10110, order 1, code 10
    check_word("R4", got, 12, exp_msb);
    check("R2", cfg_lead, 5'b10110, "cfg_lead");
    check("R7", cfg_msb_first, 1, "cfg_msb_first");
    check("R7", conv_cnt, 1, "conv_start count");
    exp_msb = 1'b1;
  endtask

  task automatic t_msb16_order_next;
    load_result(12'h3C7);
    xfer(8'h4B, 16, 1'b0, got);   // lead 01001, order 0, code 11
    check_word("R6", got, 16, exp_msb);
    check("R2", cfg_lead, 5'b01001, "cfg_lead");
    check("R2", cfg_msb_first, 0, "cfg_msb_first");
    check("R3", conv_cnt, 2, "conv_start count after 16 bits");
    exp_msb = 1'b0;
  endtask

  task automatic t_lsb8_back_to_back;
    load_result(12'h5A3);
    xfer(8'hE4, 8, 1'b1, got);    // lead 11100, order 1, code 00
    check_word("R5", got, 8, exp_msb);
    check("R3", conv_cnt, 3, "conv_start count after 8 bits");
    check("R7", cfg_lead, 5'b11100, "cfg_lead");
    exp_msb = 1'b1;
    load_result(12'h0F0);
    xfer(8'h1E, 12, 1'b0, got);   // lead 00011, order 1, code 10, cs held low
    check_word("R3", got, 12, exp_msb);
    check("R11", conv_cnt, 4, "conv_start count back to back");
    check("R3", cfg_lead, 5'b00011, "cfg_lead back to back");
  endtask

  task automatic t_abort;
    xfer(8'hFF, 5, 1'b0, got);
    check("R10", sdo_oe, 0, "sdo_oe with cs high");
    check("R10", sdo, 0, "sdo with cs high");
    check("R10", conv_cnt, 4, "conv_start after abort");
    check("R10", cfg_lead, 5'b00011, "cfg_lead after abort");
    load_result(12'h801);
    xfer(8'hAA, 12, 1'b0, got);   // lead 10101, order 0, code 10
    check_word("R10", got, 12, exp_msb);
    check("R10", conv_cnt, 5, "conv_start after fresh transfer");
    check("R7", cfg_lead, 5'b10101, "cfg_lead fresh");
    exp_msb = 1'b0;
  endtask

  task automatic t_shutdown_cs_wake;
    load_result(12'h9F1);
    xfer(8'hFD, 10, 1'b0, got);   // lead 11111, order 1, code 01
    check_word("R8", got, 10, exp_msb);
    check("R8", pwr_down, 1, "pwr_down after shutdown");
    check("R8", conv_cnt, 5, "no conv_start on shutdown");
    check("R8", cfg_lead, 5'b10101, "cfg_lead kept");
    check("R8", cfg_msb_first, 0, "cfg_msb_first kept");
    cs_n = 1'b0; #60;
    check("R9", pwr_down, 0, "pwr_down after cs fall");
    cs_n = 1'b1; #60;
  endtask

  task automatic t_shutdown_clk_wake;
    xfer(8'hFD, 10, 1'b1, got);
    check("R8", pwr_down, 1, "pwr_down with cs held low");
    #20 sclk = 1'b1;
    #60;
    check("R9", pwr_down, 0, "pwr_down after sclk rise");
    sclk = 1'b0;
    #40 cs_n = 1'b1; #60;
    check("R9", conv_cnt, 5, "no conv_start after wake edge");
  endtask

  initial begin
    #500us;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_msb12();
    t_msb16_order_next();
    t_lsb8_back_to_back();
    t_abort();
    t_shutdown_cs_wake();
    t_shutdown_clk_wake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule